// File: doc/BRIEF.md
# Column-Serial Block SAD Matcher

This block scores how well a 16x16 reference pattern fits one 16x16 candidate area of a search window. It uses the sum of absolute differences over all 256 pixel pairs. It takes one column per beat: a 16-pixel slice of the pattern and the 16-pixel slice of the window at the same position. For each beat it forms sixteen absolute differences and reduces them in a registered adder tree. It then accumulates the column sums of a candidate. When the candidate closes, it emits a single score labelled with the candidate's tag.

An upstream address generator can present candidates in any order, scattered or adjacent. Every candidate costs exactly sixteen accepted beats. A new candidate's opening column may follow the previous candidate's closing column on the very next cycle. One flag on the input opens a candidate and another closes it. A stalled score output freezes the whole pipe, and the input is refused until the score has been taken.

Top module: `col_sad_matcher`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: The score equals the sum of |pattern - window| over all 256 pixel pairs of the candidate. Pixels are 8-bit unsigned, and row r of a column sits in bits [8r+7:8r] of `pat_col` and `win_col`.
- R3: A beat with `in_first` high starts a fresh sum and discards any partial sum left by columns that never saw `in_last`.
- R4: `out_tag` equals the `in_tag` presented with the candidate's closing beat (`in_last` high).
- R5: With `out_ready` held high, candidates sent back-to-back with no idle beat give scores exactly 16 cycles apart.
- R6: With `out_ready` held high, `out_valid` is high on the fifth rising edge after the edge that accepts a closing beat.
- R7: While `out_valid` is high and `out_ready` is low, `out_score` and `out_tag` hold, `in_ready` is low, and no score is lost or duplicated.
- R8: The largest score, 65280 (every difference 255), is reported without overflow in the 16-bit score.
- R9: Cycles with `in_valid` low between columns of a candidate leave its score unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Column beat present |
| in_ready | output | 1 | Beat accepted at this edge when valid |
| in_first | input | 1 | Opening column of a candidate |
| in_last | input | 1 | Closing column of a candidate |
| in_tag | input | 8 | Candidate identifier |
| pat_col | input | 128 | Sixteen pattern pixels of one column |
| win_col | input | 128 | Sixteen window pixels of the same column |
| out_valid | output | 1 | Score present |
| out_ready | input | 1 | Downstream takes the score |
| out_score | output | 16 | Sum of absolute differences |
| out_tag | output | 8 | Tag of the scored candidate |

## Verification
The closing beat of one candidate can reach the accumulator in the same cycle as a stall. The stall comes from an earlier score still waiting at the output. At the same time, the next candidate's columns are queued in the tree. A random `out_ready` pattern is run over streams of back-to-back candidates to provoke this overlap. A scoreboard then judges it: every score must come out exactly once, in order, with the right value and tag, and must hold steady through the stall. With `out_ready` held high, the distance from the accepted closing beat to the score is checked, and so is the 16-cycle spacing between adjacent candidates.

// File: rtl/sad_pkg.sv
package sad_pkg;
  // Beat control travelling beside the data
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } beat_flags_t;

  function automatic int col_sum_bits(input int pix_w, input int rows);
    return pix_w + $clog2(rows);
  endfunction
endpackage

// File: rtl/sad_absdiff_row.sv
module sad_absdiff_row #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [ROWS*PIX_W-1:0] pat_col,
  input  logic [ROWS*PIX_W-1:0] win_col,
  output logic [ROWS*PIX_W-1:0] ad_q
);
  logic [ROWS*PIX_W-1:0] ad_d;

  for (genvar g = 0; g < ROWS; g++) begin : g_px
    logic [PIX_W-1:0] a, b;
    assign a = pat_col[g*PIX_W +: PIX_W];
    assign b = win_col[g*PIX_W +: PIX_W];
    always_comb begin
      if (a > b) ad_d[g*PIX_W +: PIX_W] = a - b;
      else       ad_d[g*PIX_W +: PIX_W] = b - a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ad_q <= '0;
    else if (en) ad_q <= ad_d;
  end
endmodule

// File: rtl/sad_tree.sv
module sad_tree #(
  parameter int IN_W  = 8,
  parameter int ROWS  = 16,
  parameter int OUT_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [ROWS*IN_W-1:0] leaf,
  output logic [OUT_W-1:0]     col_sum
);
  localparam int LVLS = $clog2(ROWS);
  localparam int MAXS = ROWS * ((1 << IN_W) - 1);

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int CNT = ROWS >> (l + 1);
    for (genvar i = 0; i < CNT; i++) begin : g_add
      logic [OUT_W-1:0] a, b, s_d, s_q;
      if (l == 0) begin : g_leaf
        assign a = {{(OUT_W-IN_W){1'b0}}, leaf[(2*i)*IN_W +: IN_W]};
        assign b = {{(OUT_W-IN_W){1'b0}}, leaf[(2*i+1)*IN_W +: IN_W]};
      end else begin : g_mid
        assign a = g_lvl[l-1].g_add[2*i].s_q;
        assign b = g_lvl[l-1].g_add[2*i+1].s_q;
      end
      assign s_d = a + b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  s_q <= '0;
        else if (en) s_q <= s_d;
      end
    end
  end

  assign col_sum = g_lvl[LVLS-1].g_add[0].s_q;

  // R2: a column sum never exceeds sixteen maximal differences
  p_colsum_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(col_sum) <= MAXS);
endmodule

// File: rtl/sad_side_pipe.sv
module sad_side_pipe
  import sad_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  beat_flags_t       fl_in,
  input  logic [TAG_W-1:0]  tag_in,
  output beat_flags_t       fl_out,
  output logic [TAG_W-1:0]  tag_out
);
  beat_flags_t      fl_q [DEPTH];
  logic [TAG_W-1:0] tg_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        fl_q[k] <= '0;
        tg_q[k] <= '0;
      end
    end else if (en) begin
      fl_q[0] <= fl_in;
      tg_q[0] <= tag_in;
      for (int k = 1; k < DEPTH; k++) begin
        fl_q[k] <= fl_q[k-1];
        tg_q[k] <= tg_q[k-1];
      end
    end
  end

  assign fl_out  = fl_q[DEPTH-1];
  assign tag_out = tg_q[DEPTH-1];
endmodule

// File: rtl/sad_col_accum.sv
module sad_col_accum
  import sad_pkg::*;
#(
  parameter int SUM_W = 12,
  parameter int ACC_W = 16,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  beat_flags_t      fl,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [SUM_W-1:0] col_sum,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_score,
  output logic [TAG_W-1:0] out_tag
);
  logic [ACC_W-1:0] acc_q, acc_d, base;
  logic [ACC_W:0]   total;
  logic             ov_d;
  logic [ACC_W-1:0] sc_d;
  logic [TAG_W-1:0] tg_d;

  always_comb begin
    base  = fl.first ? '0 : acc_q;
    total = {1'b0, base} + {{(ACC_W+1-SUM_W){1'b0}}, col_sum};
    acc_d = acc_q;
    ov_d  = 1'b0;
    sc_d  = out_score;
    tg_d  = out_tag;
    if (fl.vld) begin
      acc_d = total[ACC_W-1:0];
      if (fl.last) begin
        ov_d = 1'b1;
        sc_d = total[ACC_W-1:0];
        tg_d = tag_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_score <= '0;
      out_tag   <= '0;
    end else if (en) begin
      acc_q     <= acc_d;
      out_valid <= ov_d;
      out_score <= sc_d;
      out_tag   <= tg_d;
    end
  end

  // R8: accumulation within a candidate never carries out of the score width
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fl.vld) |-> !total[ACC_W]);

  // R6: a score only appears after a closing beat reached this stage
  p_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(en && fl.vld && fl.last));
endmodule

// File: rtl/col_sad_matcher.sv
module col_sad_matcher
  import sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int TAG_W = 8,
  localparam int SUM_W = col_sum_bits(PIX_W, ROWS),
  localparam int ACC_W = SUM_W + $clog2(COLS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_first,
  input  logic                  in_last,
  input  logic [TAG_W-1:0]      in_tag,
  input  logic [ROWS*PIX_W-1:0] pat_col,
  input  logic [ROWS*PIX_W-1:0] win_col,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ACC_W-1:0]      out_score,
  output logic [TAG_W-1:0]      out_tag
);
  localparam int LVLS  = $clog2(ROWS);
  localparam int DEPTH = 1 + LVLS;

  logic                  advance;
  logic [ROWS*PIX_W-1:0] ad_q;
  logic [SUM_W-1:0]      col_sum;
  beat_flags_t           fl_in, fl_acc;
  logic [TAG_W-1:0]      tag_acc;

  // Whole pipe moves only when the output slot is free or being emptied
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  always_comb begin
    fl_in.vld   = in_valid;
    fl_in.first = in_first;
    fl_in.last  = in_last;
  end

  sad_absdiff_row #(.PIX_W(PIX_W), .ROWS(ROWS)) u_ad (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .pat_col(pat_col), .win_col(win_col), .ad_q(ad_q)
  );

  sad_tree #(.IN_W(PIX_W), .ROWS(ROWS), .OUT_W(SUM_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .leaf(ad_q), .col_sum(col_sum)
  );

  sad_side_pipe #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_side (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .fl_in(fl_in), .tag_in(in_tag),
    .fl_out(fl_acc), .tag_out(tag_acc)
  );

  sad_col_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W), .TAG_W(TAG_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(advance),
    .fl(fl_acc), .tag_in(tag_acc), .col_sum(col_sum),
    .out_valid(out_valid), .out_score(out_score), .out_tag(out_tag)
  );

  // R7: a refused score stays put with its tag
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_score) && $stable(out_tag)));
endmodule

// File: tb/sim_col_sad_matcher.sv
module sim_col_sad_matcher;
  localparam int CLK_T = 10;
  localparam int WD    = 100000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, in_first, in_last;
  logic [7:0]   in_tag;
  logic [127:0] pat_col, win_col;
  logic         out_valid, out_ready;
  logic [15:0]  out_score;
  logic [7:0]   out_tag;

  col_sad_matcher u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_tag(in_tag),
    .pat_col(pat_col), .win_col(win_col), .out_valid(out_valid),
    .out_ready(out_ready), .out_score(out_score), .out_tag(out_tag)
  );

  always #(CLK_T/2) clk = ~clk;

  typedef struct {
    int score;
    int tag;
    int edge_no;
    bit lat;
    bit b2b;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0;
  bit          run_mon = 0, bp_mode = 0, done = 0;
  int unsigned lcg = 32'h1234_5678, lcg_bp = 32'h0bad_cafe;
  bit          pv = 0, pr = 0;
  logic [15:0] ps;
  logic [7:0]  pt;
  int          prev_obs = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd8();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:16];
  endfunction

  // Backpressure driver: updated just after each edge
  always @(posedge clk) begin
    #2;
    if (bp_mode) begin
      lcg_bp = lcg_bp * 32'd1664525 + 32'd1013904223;
      out_ready = lcg_bp[20] | lcg_bp[9];
    end else begin
      out_ready = 1'b1;
    end
  end

  // One beat: held until accepted at a rising edge
  task automatic drive_beat(input logic [127:0] p, input logic [127:0] w,
                            input bit f, input bit l, input int tag,
                            input bit push, input exp_t item);
    @(negedge clk);
    pat_col = p; win_col = w; in_first = f; in_last = l;
    in_tag = tag[7:0]; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (push) begin
      item.edge_no = cyc + 1;
      q.push_back(item);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // mode 0 random, 1 maximal difference, 2 identical areas
  task automatic send_cand(input int tag, input int mode, input int gap,
                           input bit lat, input bit b2b);
    logic [7:0]   p [16][16];
    logic [7:0]   w [16][16];
    logic [127:0] pc, wc;
    exp_t         it;
    int           s = 0;
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 16; c++) begin
        case (mode)
          1:       begin p[r][c] = 8'd255; w[r][c] = 8'd0; end
          2:       begin p[r][c] = rnd8(); w[r][c] = p[r][c]; end
          default: begin p[r][c] = rnd8(); w[r][c] = rnd8(); end
        endcase
        s += (p[r][c] > w[r][c]) ? int'(p[r][c] - w[r][c]) : int'(w[r][c] - p[r][c]);
      end
    end
    it.score = s; it.tag = tag; it.edge_no = 0; it.lat = lat; it.b2b = b2b;
    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 16; r++) begin
        pc[r*8 +: 8] = p[r][c];
        wc[r*8 +: 8] = w[r][c];
      end
      drive_beat(pc, wc, c == 0, c == 15, tag, c == 15, it);
      if (gap > 0 && c < 15) repeat (gap) @(negedge clk);
    end
  endtask

  // Opening columns of an abandoned candidate (no closing beat)
  task automatic send_partial(input int n);
    exp_t it;
    it.score = 0; it.tag = 0; it.edge_no = 0; it.lat = 0; it.b2b = 0;
    for (int c = 0; c < n; c++)
      drive_beat({16{8'd200}}, {16{8'd3}}, c == 0, 1'b0, 8'hEE, 1'b0, it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (run_mon) begin
      if (pv && !pr) begin
        chk(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
        chk(out_score == ps, "R7 score held", int'(out_score), int'(ps));
        chk(out_tag == pt, "R7 tag held", int'(out_tag), int'(pt));
      end
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R7 input refused", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 R7 unexpected score", int'(out_score), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(out_score) == e.score, "R2 score", int'(out_score), e.score);
          chk(int'(out_tag) == e.tag, "R4 tag", int'(out_tag), e.tag);
          if (e.lat)
            chk(cyc - e.edge_no == 5, "R6 latency", cyc - e.edge_no, 5);
          if (e.b2b && prev_obs >= 0)
            chk(cyc - prev_obs == 16, "R5 spacing", cyc - prev_obs, 16);
          prev_obs = cyc;
        end
      end
      pv = out_valid; pr = out_ready; ps = out_score; pt = out_tag;
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", q.size(), 0);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    in_tag = '0; pat_col = '0; win_col = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    run_mon = 1;

    // Single candidate, exact latency
    send_cand(8'h11, 0, 0, 1, 0);
    drain();
    // Back-to-back stream: first of the run carries no spacing check
    prev_obs = -1;
    send_cand(8'h21, 0, 0, 1, 1);
    send_cand(8'h22, 1, 0, 1, 1);   // R8 maximum 65280
    send_cand(8'h23, 2, 0, 1, 1);   // zero score
    send_cand(8'h24, 0, 0, 1, 1);
    drain();
    // R9: idle cycles inside a candidate
    send_cand(8'h31, 0, 2, 0, 0);
    send_cand(8'h32, 1, 3, 0, 0);
    drain();
    // R3: abandoned partial sum, then a fresh candidate
    send_partial(5);
    send_cand(8'h41, 0, 0, 0, 0);
    drain();
    // R7: random backpressure over back-to-back candidates
    bp_mode = 1;
    for (int k = 0; k < 8; k++) send_cand(8'h50 + k, k % 3, 0, 0, 0);
    drain();
    bp_mode = 0;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7 no lost score", q.size(), 0);
    chk(out_valid == 1'b0, "R7 no duplicate score", int'(out_valid), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule